// File: doc/BRIEF.md
# Keyed-Enable Watchdog Timer

This block is a watchdog that runs on a slow, always-on clock and counts up to a selectable power-of-two limit. Software must restart the count with a clear strobe before the limit is reached. If it fails to do so, the block raises a reset request. The halt strobe restarts the count in the same way as the clear strobe. When the limit is reached in normal run mode, the block issues a full device reset. When the limit is reached while the system is sleeping or idle, it issues only a partial reset, which restarts the program counter and stack pointer. In both cases a timeout status flag is set.

Counting is gated by a five-bit key field. Only two bit patterns count as valid. Any other value, whether written on purpose or produced by a disturbance, is treated as a software reset request. A short synchronizer chain delays it, and then it produces a full reset pulse. That pulse also puts the key field back to its power-on pattern, clears the counter and sets a sticky flag. Software can clear the sticky flag only by writing zero to it.

A small register port reaches the block. Address 0 holds the key field and the timeout select. Address 1 holds the status flags.

Top module: `wdt_keyed`

## Requirements
- R1: After reset, address 0 reads 8'hEA (select 3'b111 in bits 7:5, key 5'b01010 in bits 4:0), address 1 reads 8'h00, both reset outputs are low and counting is active.
- R2: The counter advances only while the key field (bits 4:0 of address 0) equals 5'b01010 or 5'b10101. A write to address 0 loads bits 7:5 into the select and bits 4:0 into the key, and reads return the same layout.
- R3: Select codes 0 to 7 choose limits of 2^8, 2^10, 2^12, 2^14, 2^15, 2^16, 2^17 and 2^18 slow cycles, counted from the edge at which the count was cleared.
- R4: When the limit is reached with sleep low, rst_full_o is high for exactly one cycle, on the cycle after the limit edge, and the timeout flag (address 1 bit 1) becomes 1.
- R5: When the limit is reached with sleep high, rst_part_o pulses for one cycle instead, rst_full_o stays low, and the timeout flag becomes 1.
- R6: A clear or halt strobe zeroes the counter and the timeout flag. It takes priority over an overflow on the same edge, so no reset pulse follows.
- R7: If the key field holds an invalid value, rst_full_o pulses for one cycle after the third rising edge that follows the write edge. At that point the key returns to 5'b01010, the counter clears, the sticky flag (address 1 bit 0) is set and the timeout flag is kept. This happens even if a valid key is written back one cycle later.
- R8: The sticky flag is cleared only by a write to address 1 with bit 0 equal to 0. Writing 1 to bit 0 has no effect, and the timeout flag cannot be written.
- R9: After an overflow the counter restarts from zero, so further timeouts follow at the same period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow watchdog clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| clr_i | input | 1 | Clear-watchdog strobe |
| halt_i | input | 1 | Halt strobe, also clears the count |
| sleep_i | input | 1 | High while in sleep or idle mode |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Register write address (0 control, 1 flags) |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 1 | Register read address |
| rd_data_o | output | 8 | Register read data |
| rst_full_o | output | 1 | Full device reset pulse |
| rst_part_o | output | 1 | Partial reset pulse (program counter and stack) |
| to_o | output | 1 | Timeout status flag |
| swrst_flag_o | output | 1 | Sticky invalid-key reset flag |

## Verification
A clear or halt strobe takes effect at the edge that samples it. An overflow pulse appears on the cycle after the edge at which the count reaches its limit, which is exactly 2^n edges after the clearing edge. An invalid key produces its pulse three edges after the write edge. Register writes and flag changes are visible one edge after they are sampled. The bench drives inputs on falling edges and compares every output against a behavioural model on each falling edge, so every result is sampled in the cycle it is due. Directed checks also count falling edges from each stimulus to the exact cycle at which a pulse must appear and the cycles around it at which it must not.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Width of the timeout select field.
  localparam int SEL_W = 3;

  // Maps a select code to the log2 of the timeout limit.
  function automatic int unsigned limit_log2(input logic [SEL_W-1:0] sel);
    int unsigned e;
    case (sel)
      3'd0:    e = 8;
      3'd1:    e = 10;
      3'd2:    e = 12;
      3'd3:    e = 14;
      3'd4:    e = 15;
      3'd5:    e = 16;
      3'd6:    e = 17;
      default: e = 18;
    endcase
    return e;
  endfunction

  // Flags register bit positions.
  localparam int FLAG_SW_BIT = 0;
  localparam int FLAG_TO_BIT = 1;

endpackage

// File: rtl/wdt_key_guard.sv
module wdt_key_guard #(
  parameter int                 KEY_W  = 5,
  parameter logic [KEY_W-1:0]   KEY_A  = 5'b01010,
  parameter logic [KEY_W-1:0]   KEY_B  = 5'b10101,
  parameter int                 STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [KEY_W-1:0] key_i,
  output logic             key_ok_o,
  output logic             fire_o,
  output logic             pulse_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              pulse_q;
  logic              pulse_d;
  logic              key_bad;

  assign key_ok_o = (key_i == KEY_A) || (key_i == KEY_B);
  assign key_bad  = ~key_ok_o;
  assign fire_o   = sync_q[STAGES-1];

  // The first stage samples the key check. A firing edge flushes the whole chain.
  always_comb begin
    sync_d[0] = fire_o ? 1'b0 : key_bad;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_chain
    always_comb begin
      sync_d[g] = fire_o ? 1'b0 : sync_q[g-1];
    end
  end

  always_comb begin
    pulse_d = fire_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      sync_q  <= sync_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int               KEY_W   = 5,
  parameter logic [KEY_W-1:0] KEY_RST = 5'b01010,
  parameter logic [SEL_W-1:0] SEL_RST = 3'b111,
  localparam int              DATA_W  = KEY_W + SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              fire_i,
  output logic [KEY_W-1:0]  key_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              swf_o
);

  logic [KEY_W-1:0] key_q, key_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             swf_q, swf_d;
  logic             ctl_we;
  logic             flg_we;

  assign ctl_we = wr_en_i && !wr_addr_i;
  assign flg_we = wr_en_i &&  wr_addr_i;

  always_comb begin
    key_d = key_q;
    sel_d = sel_q;
    swf_d = swf_q;
    if (fire_i) begin
      key_d = KEY_RST;
      swf_d = 1'b1;
    end else if (ctl_we) begin
      key_d = wr_data_i[KEY_W-1:0];
      sel_d = wr_data_i[DATA_W-1:KEY_W];
    end else if (flg_we && !wr_data_i[FLAG_SW_BIT]) begin
      swf_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q <= KEY_RST;
      sel_q <= SEL_RST;
      swf_q <= 1'b0;
    end else begin
      key_q <= key_d;
      sel_q <= sel_d;
      swf_q <= swf_d;
    end
  end

  assign key_o = key_q;
  assign sel_o = sel_q;
  assign swf_o = swf_q;

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int CNT_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             key_ok_i,
  input  logic             fire_i,
  input  logic             clr_i,
  input  logic             halt_i,
  input  logic             sleep_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             to_o,
  output logic             full_o,
  output logic             part_o
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] lim_m1;
  logic             to_q, to_d;
  logic             full_q, full_d;
  logic             part_q, part_d;
  logic             restart;
  logic             at_limit;

  // The last count value before overflow, taken from the select code.
  always_comb begin
    span   = {{CNT_W{1'b0}}, 1'b1} << limit_log2(sel_i);
    lim_m1 = span[CNT_W-1:0] - CNT_ONE;
  end

  assign restart  = clr_i || halt_i;
  assign at_limit = cnt_q >= lim_m1;

  always_comb begin
    cnt_d  = cnt_q;
    to_d   = to_q;
    full_d = 1'b0;
    part_d = 1'b0;
    if (fire_i) begin
      cnt_d = '0;
    end else if (restart) begin
      cnt_d = '0;
      to_d  = 1'b0;
    end else if (key_ok_i) begin
      if (at_limit) begin
        cnt_d  = '0;
        to_d   = 1'b1;
        full_d = !sleep_i;
        part_d = sleep_i;
      end else begin
        cnt_d = cnt_q + CNT_ONE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      to_q   <= 1'b0;
      full_q <= 1'b0;
      part_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      to_q   <= to_d;
      full_q <= full_d;
      part_q <= part_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign to_o   = to_q;
  assign full_o = full_q;
  assign part_o = part_q;

endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_pkg::*;
#(
  parameter int               KEY_W   = 5,
  parameter logic [KEY_W-1:0] KEY_A   = 5'b01010,
  parameter logic [KEY_W-1:0] KEY_B   = 5'b10101,
  parameter logic [SEL_W-1:0] SEL_RST = 3'b111,
  parameter int               CNT_W   = 18,
  parameter int               STAGES  = 2,
  localparam int              DATA_W  = KEY_W + SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              halt_i,
  input  logic              sleep_i,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rst_full_o,
  output logic              rst_part_o,
  output logic              to_o,
  output logic              swrst_flag_o
);

  logic [KEY_W-1:0] key_q;
  logic [SEL_W-1:0] sel_q;
  logic             swf_q;
  logic             key_ok;
  logic             fire;
  logic             fire_pulse;
  logic [CNT_W-1:0] cnt_q;
  logic             to_q;
  logic             ovf_full;
  logic             ovf_part;
  logic [DATA_W-1:0] flag_word;

  wdt_regs #(
    .KEY_W  (KEY_W),
    .KEY_RST(KEY_A),
    .SEL_RST(SEL_RST)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .fire_i   (fire),
    .key_o    (key_q),
    .sel_o    (sel_q),
    .swf_o    (swf_q)
  );

  wdt_key_guard #(
    .KEY_W (KEY_W),
    .KEY_A (KEY_A),
    .KEY_B (KEY_B),
    .STAGES(STAGES)
  ) u_guard (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .key_i   (key_q),
    .key_ok_o(key_ok),
    .fire_o  (fire),
    .pulse_o (fire_pulse)
  );

  wdt_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .key_ok_i(key_ok),
    .fire_i  (fire),
    .clr_i   (clr_i),
    .halt_i  (halt_i),
    .sleep_i (sleep_i),
    .sel_i   (sel_q),
    .cnt_o   (cnt_q),
    .to_o    (to_q),
    .full_o  (ovf_full),
    .part_o  (ovf_part)
  );

  always_comb begin
    flag_word              = '0;
    flag_word[FLAG_SW_BIT] = swf_q;
    flag_word[FLAG_TO_BIT] = to_q;
  end

  assign rd_data_o    = rd_addr_i ? flag_word : {sel_q, key_q};
  assign rst_full_o   = fire_pulse | ovf_full;
  assign rst_part_o   = ovf_part;
  assign to_o         = to_q;
  assign swrst_flag_o = swf_q;

endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk #(
  parameter int CNT_W = 18
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             halt_i,
  input logic             sleep_i,
  input logic             wr_en_i,
  input logic             wr_addr_i,
  input logic             wr_bit0_i,
  input logic             rst_full_i,
  input logic             rst_part_i,
  input logic             to_i,
  input logic             swf_i,
  input logic             key_ok_i,
  input logic             fire_i,
  input logic [CNT_W-1:0] cnt_i
);

  AST_PART_NEEDS_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_part_i |-> $past(sleep_i)); // R5

  AST_ONE_RESET_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rst_part_i && rst_full_i)); // R5

  AST_CLEAR_DROPS_TO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i || halt_i) && !fire_i) |=> (!to_i && !rst_full_i && !rst_part_i)); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swf_i && !(wr_en_i && wr_addr_i && !wr_bit0_i)) |=> swf_i); // R8

  AST_BAD_KEY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!key_ok_i && !fire_i && !clr_i && !halt_i) |=> $stable(cnt_i)); // R2

  AST_FIRE_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> (rst_full_i && swf_i && cnt_i == '0)); // R7

endmodule

bind wdt_keyed wdt_keyed_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clr_i     (clr_i),
  .halt_i    (halt_i),
  .sleep_i   (sleep_i),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_bit0_i (wr_data_i[0]),
  .rst_full_i(rst_full_o),
  .rst_part_i(rst_part_o),
  .to_i      (to_o),
  .swf_i     (swrst_flag_o),
  .key_ok_i  (key_ok),
  .fire_i    (fire),
  .cnt_i     (cnt_q)
);

// File: tb/wdt_keyed_test.sv
module wdt_keyed_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0, halt = 1'b0, sleep = 1'b0;
  logic       wr_en = 1'b0, wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_addr = 1'b0;
  logic [7:0] rd_data;
  logic       rst_full, rst_part, to_flag, swf;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  // Reference model state
  int m_key, m_sel, m_to, m_wrf, m_cnt, m_s1, m_s2, m_pf, m_full, m_part;

  wdt_keyed uut (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .halt_i(halt), .sleep_i(sleep),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .rst_full_o(rst_full), .rst_part_o(rst_part), .to_o(to_flag),
    .swrst_flag_o(swf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int limit_of(input int s);
    case (s)
      0: return 256;
      1: return 1024;
      2: return 4096;
      3: return 16384;
      4: return 32768;
      5: return 65536;
      6: return 131072;
      default: return 262144;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at t=%0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural model, updated on each rising edge
  always @(posedge clk) begin : model
    int fire, bad, ok, n_key, n_sel, n_wrf, n_cnt, n_to, n_full, n_part;
    if (!rst_n) begin
      m_key = 10; m_sel = 7; m_to = 0; m_wrf = 0; m_cnt = 0;
      m_s1 = 0; m_s2 = 0; m_pf = 0; m_full = 0; m_part = 0;
    end else begin
      fire = m_s2;
      ok   = (m_key == 10 || m_key == 21) ? 1 : 0;
      bad  = 1 - ok;
      n_key = m_key; n_sel = m_sel; n_wrf = m_wrf;
      n_cnt = m_cnt; n_to = m_to; n_full = 0; n_part = 0;
      if (fire == 1) begin
        n_key = 10; n_wrf = 1;
      end else if (wr_en && !wr_addr) begin
        n_key = int'(wr_data[4:0]); n_sel = int'(wr_data[7:5]);
      end else if (wr_en && wr_addr && !wr_data[0]) begin
        n_wrf = 0;
      end
      if (fire == 1) begin
        n_cnt = 0;
      end else if (clr || halt) begin
        n_cnt = 0; n_to = 0;
      end else if (ok == 1) begin
        if (m_cnt >= limit_of(m_sel) - 1) begin
          n_cnt = 0; n_to = 1;
          if (sleep) n_part = 1; else n_full = 1;
        end else begin
          n_cnt = m_cnt + 1;
        end
      end
      if (fire == 1) begin
        m_s2 = 0; m_s1 = 0;
      end else begin
        m_s2 = m_s1; m_s1 = bad;
      end
      m_pf = fire;
      m_key = n_key; m_sel = n_sel; m_wrf = n_wrf;
      m_cnt = n_cnt; m_to = n_to; m_full = n_full; m_part = n_part;
    end
  end

  // Per-cycle comparison on falling edges; read address alternates
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R4/R7 rst_full vs model", rst_full, (m_pf | m_full));
      check("R5 rst_part vs model", rst_part, m_part);
      check("R6 timeout flag vs model", to_flag, m_to);
      check("R8 sticky flag vs model", swf, m_wrf);
      if (rd_addr)
        check("R8 flags read vs model", rd_data, (m_to << 1) | m_wrf);
      else
        check("R2 control read vs model", rd_data, (m_sel << 5) | m_key);
    end
    rd_addr <= ~rd_addr;
  end

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=<%0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic strobe_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic strobe_halt();
    @(negedge clk); halt = 1'b1;
    @(negedge clk); halt = 1'b0;
  endtask

  initial begin
    idle(3);
    // R1: reset state
    check("R1 rst_full low", rst_full, 1'b0);
    check("R1 rst_part low", rst_part, 1'b0);
    check("R1 timeout flag", to_flag, 1'b0);
    check("R1 sticky flag", swf, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    check("R1 outputs after release", {rst_full, rst_part, to_flag, swf}, 4'b0000);

    // R3/R4: select 0 (256 cycles), clear, then exact pulse cycle
    reg_write(1'b0, 8'h0A);
    strobe_clr();
    idle(255);
    check("R3 no pulse one cycle early", rst_full, 1'b0);
    idle(1);
    check("R4 full pulse at limit", rst_full, 1'b1);
    check("R4 timeout flag set", to_flag, 1'b1);
    check("R4 no partial in run mode", rst_part, 1'b0);
    idle(1);
    check("R4 pulse one cycle wide", rst_full, 1'b0);

    // R9: next timeout at the same period
    idle(254);
    check("R9 no early second pulse", rst_full, 1'b0);
    idle(1);
    check("R9 second pulse", rst_full, 1'b1);

    // R6: clear drops timeout flag; halt restarts count too
    strobe_clr();
    check("R6 clear drops flag", to_flag, 1'b0);
    idle(100);
    strobe_halt();
    idle(200);
    check("R6 halt restarted count", rst_full, 1'b0);
    // R6: clear on the overflow edge wins
    strobe_clr();
    idle(254);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    check("R6 clear beats overflow", rst_full, 1'b0);
    check("R6 flag stays low", to_flag, 1'b0);

    // R5: sleep mode, select 1 (1024)
    sleep = 1'b1;
    reg_write(1'b0, 8'h2A);
    strobe_clr();
    idle(1023);
    check("R5 no early partial", rst_part, 1'b0);
    idle(1);
    check("R5 partial pulse", rst_part, 1'b1);
    check("R5 no full pulse", rst_full, 1'b0);
    check("R5 timeout flag set", to_flag, 1'b1);
    @(negedge clk); sleep = 1'b0;

    // R7: invalid key, flag and timeout bookkeeping
    reg_write(1'b0, 8'h3F);
    idle(2);
    check("R7 no pulse before third edge", rst_full, 1'b0);
    idle(1);
    check("R7 invalid key full pulse", rst_full, 1'b1);
    check("R7 sticky flag set", swf, 1'b1);
    check("R7 timeout kept", to_flag, 1'b1);
    idle(1);
    check("R7 single pulse", rst_full, 1'b0);

    // R8: write 1 ignored, write 0 clears, timeout not writable
    reg_write(1'b1, 8'h01);
    idle(1);
    check("R8 write one ignored", swf, 1'b1);
    reg_write(1'b1, 8'h00);
    idle(1);
    check("R8 write zero clears", swf, 1'b0);
    check("R8 timeout not writable", to_flag, 1'b1);

    // R7: bad key corrected one cycle later still fires
    reg_write(1'b0, 8'h2F);
    reg_write(1'b0, 8'h2A);
    idle(1);
    check("R7 corrected key still fires", rst_full, 1'b1);
    check("R7 sticky set again", swf, 1'b1);

    // R2: second valid key counts to a timeout
    reg_write(1'b0, 8'h35);
    strobe_clr();
    idle(1023);
    check("R2 key 10101 no early pulse", rst_full, 1'b0);
    idle(1);
    check("R2 key 10101 counts to limit", rst_full, 1'b1);
    idle(20);

    finish_run();
  end

endmodule